// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side command decoder of a serial NOR flash. A host talks to it over a four-wire SPI link in mode 0: it pulls the active-low select low, clocks 8-bit bus cycles most significant bit first, and raises the select to end the command. The block samples the link with its own system clock, splits the traffic into bus cycles, decodes the first cycle as an opcode, gathers a 24-bit address, and drives array data, status or identification bytes back on the serial output.

On the write side it keeps a write-enable latch and turns complete program, erase and status-write commands into single-cycle strobes for a memory back end. Each strobe carries an address and a data byte. Read commands raise a read strobe with an address, and the back end answers on `rd_data` by the next cycle. Read-back commands keep streaming for as long as the host keeps clocking. A status write is honoured only when it directly follows an unlock or a write-enable command.

Top module: `sflash_cmd_front`

## Requirements
- R1: Every bus cycle is 8 SCK periods. Bits are taken MSB first on the rising SCK edge while `cs_n` is low, and the serial output changes only after a falling SCK edge.
- R2: If `cs_n` rises part-way through a bus cycle, the command is dropped: no strobe, and no change to the write-enable latch or the status bits.
- R3: Opcode 06h sets the write-enable latch. Opcode 04h clears it and also ends a sequential-program run. The latch reads back as bit 1 of the status byte.
- R4: Opcodes 02h, AFh, 20h and 60h are ignored while the write-enable latch is clear. A byte program, sector erase or chip erase that is issued clears the latch.
- R5: Program, erase and status-write strobes pulse for one clock, at most one at a time. They fire only when `cs_n` rises after a complete final bus cycle.
- R6: Byte program 02h takes three address bytes, high byte first, and then one data byte. It issues `prog_req` with that address and data.
- R7: Sector erase 20h takes three address bytes and issues `serase_req` with address bits 11..0 forced to zero. Chip erase 60h needs only the opcode and issues `cerase_req`.
- R8: Opcode AFh with three address bytes and a data byte programs that address and starts a sequential run. While the run lasts, AFh followed by a single data byte programs the next address, and the latch stays set.
- R9: Status write 01h followed by one data byte takes effect only in the frame right after a frame of 50h or 06h. It then issues `wrsr_req`, stores data bits 7..2 and clears the latch. The status byte is {stored bits 7..2, latch, `busy`}.
- R10: Read 03h takes three address bytes. From the fifth bus cycle on it returns one array byte per cycle from consecutive addresses until `cs_n` rises.
- R11: Fast read 0Bh adds one dummy bus cycle after the address, so data starts in the sixth bus cycle and then streams like R10.
- R12: Opcode 05h returns the current status byte in every bus cycle after the opcode until `cs_n` rises.
- R13: Opcode 9Fh returns the identification bytes 8Ch, 8Ch, 8Ch in every bus cycle after the opcode, and the pattern repeats until `cs_n` rises.
- R14: `miso_oe` is high only during bus cycles that return data. Unknown opcodes produce no output and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| busy | input | 1 | Back end busy flag, shown in status bit 0 |
| rd_req | output | 1 | Read strobe, one clock |
| rd_addr | output | 24 | Array address for `rd_req` |
| rd_data | input | 8 | Array byte returned the clock after `rd_req` |
| prog_req | output | 1 | Program-byte strobe |
| serase_req | output | 1 | Sector-erase strobe |
| cerase_req | output | 1 | Chip-erase strobe |
| wrsr_req | output | 1 | Status-write strobe |
| wr_addr | output | 24 | Address for program and sector erase |
| wr_data | output | 8 | Data byte for program and status write |

## Verification
Reads are run at addresses whose low byte rolls over during the stream, so a stuck or late address counter shows up in the returned bytes. A fast read follows to show that the dummy cycle shifts the data by exactly one bus cycle. Write commands are sent with the latch both set and clear, and once cut off mid-cycle, so an ungated or early strobe can be told apart from a correct one. The status write is tried right after an unlock, with a status read in between, and right after a write enable; these three cases separate the adjacency rule from plain latch gating.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam logic [7:0] OP_READ        = 8'h03;
  localparam logic [7:0] OP_READ_FAST   = 8'h0B;
  localparam logic [7:0] OP_ERASE_SECT  = 8'h20;
  localparam logic [7:0] OP_ERASE_ALL   = 8'h60;
  localparam logic [7:0] OP_PROG_BYTE   = 8'h02;
  localparam logic [7:0] OP_PROG_SEQ    = 8'hAF;
  localparam logic [7:0] OP_STAT_RD     = 8'h05;
  localparam logic [7:0] OP_STAT_UNLOCK = 8'h50;
  localparam logic [7:0] OP_STAT_WR     = 8'h01;
  localparam logic [7:0] OP_WE_SET      = 8'h06;
  localparam logic [7:0] OP_WE_CLR      = 8'h04;
  localparam logic [7:0] OP_ID_RD       = 8'h9F;

  // number of the bus cycle that completes a command (opcode is cycle 1)
  function automatic logic [3:0] last_cycle_no(input logic [7:0] op,
                                               input logic       seq_on,
                                               input logic [3:0] addr_done);
    case (op)
      OP_PROG_BYTE:  return addr_done + 4'd1;
      OP_PROG_SEQ:   return seq_on ? 4'd2 : addr_done + 4'd1;
      OP_ERASE_SECT: return addr_done;
      OP_STAT_WR:    return 4'd2;
      default:       return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_high,
  output logic cs_rise,
  output logic mosi_s
);
  logic [STAGES:0]   sck_p;
  logic [STAGES:0]   cs_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[STAGES-1:0], sck};
      cs_p   <= {cs_p[STAGES-1:0], cs_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_high  = cs_p[STAGES-1];
  assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
  assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/sfl_rx.sv
module sfl_rx #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_rise,
  input  logic          cs_high,
  input  logic          mosi_s,
  output logic [2:0]    bit_cnt,
  output logic [CW-1:0] byte_cnt,
  output logic          byte_done,
  output logic [7:0]    rx_byte
);
  logic [6:0] sh;

  always_ff @(posedge clk) begin
    if (rst || cs_high) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      byte_done <= 1'b0;
      sh        <= '0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        sh      <= {sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {sh, mosi_s};
          if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

  // a finished bus cycle always lands on a cycle boundary
  AST_DONE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (bit_cnt == 3'd0 && byte_cnt != '0)); // R1
endmodule

// File: rtl/sfl_tx.sv
module sfl_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_fall,
  input  logic       cs_high,
  input  logic       at_boundary,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  output logic       miso,
  output logic       miso_oe
);
  logic [7:0] sh;
  logic       oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      oe_q <= 1'b0;
    end else if (cs_high) begin
      oe_q <= 1'b0;
    end else if (sck_fall) begin
      if (at_boundary) begin
        oe_q <= load_en;
        sh   <= load_en ? load_byte : 8'h00;
      end else begin
        sh <= {sh[6:0], 1'b0};
      end
    end
  end

  assign miso    = sh[7];
  assign miso_oe = oe_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sck_fall |=> $stable(sh)); // R1
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_high |=> !miso_oe); // R14
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front #(
  parameter int         ADDR_BYTES  = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         SECTOR_LSB  = 12,
  parameter logic [7:0] ID_MFR      = 8'h8C,
  parameter logic [7:0] ID_TYPE     = 8'h8C,
  parameter logic [7:0] ID_CAP      = 8'h8C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic                    mosi,
  output logic                    miso,
  output logic                    miso_oe,
  input  logic                    busy,
  output logic                    rd_req,
  output logic [8*ADDR_BYTES-1:0] rd_addr,
  input  logic [7:0]              rd_data,
  output logic                    prog_req,
  output logic                    serase_req,
  output logic                    cerase_req,
  output logic                    wrsr_req,
  output logic [8*ADDR_BYTES-1:0] wr_addr,
  output logic [7:0]              wr_data
);
  import sflash_pkg::*;

  localparam int       AW        = 8 * ADDR_BYTES;
  localparam int       CW        = 4;
  localparam logic [CW-1:0] ADDR_DONE = CW'(ADDR_BYTES + 1);
  localparam logic [AW-1:0] SECT_MASK = {{(AW-SECTOR_LSB){1'b1}}, {SECTOR_LSB{1'b0}}};

  logic          sck_rise, sck_fall, cs_high, cs_rise, mosi_s;
  logic [2:0]    bit_cnt;
  logic [CW-1:0] byte_cnt;
  logic          byte_done;
  logic [7:0]    rx_byte;

  sfl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_high(cs_high),
    .cs_rise(cs_rise), .mosi_s(mosi_s));

  sfl_rx #(.CW(CW)) u_rx (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .cs_high(cs_high),
    .mosi_s(mosi_s), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
    .byte_done(byte_done), .rx_byte(rx_byte));

  logic [7:0]    op_q, data_q;
  logic [5:0]    sr_q;
  logic [AW-1:0] addr_q, rd_ptr, seq_ptr;
  logic          we_q, arm_q, seq_on;
  logic [1:0]    id_sel;

  logic [AW-1:0] full_addr, next_rd;
  logic [CW-1:0] final_no, data_start;
  logic          is_read, complete;
  logic          load_en;
  logic [7:0]    load_byte, status_byte, id_byte;

  always_comb begin
    full_addr   = {addr_q[AW-9:0], rx_byte};
    next_rd     = (byte_cnt == ADDR_DONE) ? full_addr : rd_ptr;
    final_no    = last_cycle_no(op_q, seq_on, ADDR_DONE);
    is_read     = (op_q == OP_READ) || (op_q == OP_READ_FAST);
    data_start  = (op_q == OP_READ) ? ADDR_DONE : ADDR_DONE + 1'b1;
    complete    = cs_rise && (bit_cnt == 3'd0) && (byte_cnt != '0) && (byte_cnt >= final_no);
    status_byte = {sr_q, we_q, busy};
    case (id_sel)
      2'd0:    id_byte = ID_MFR;
      2'd1:    id_byte = ID_TYPE;
      default: id_byte = ID_CAP;
    endcase
    load_en   = 1'b0;
    load_byte = 8'h00;
    if (byte_cnt != '0) begin
      case (op_q)
        OP_READ, OP_READ_FAST: if (byte_cnt >= data_start) begin
          load_en = 1'b1; load_byte = rd_data;
        end
        OP_STAT_RD: begin load_en = 1'b1; load_byte = status_byte; end
        OP_ID_RD:   begin load_en = 1'b1; load_byte = id_byte; end
        default: ;
      endcase
    end
  end

  sfl_tx u_tx (
    .clk(clk), .rst(rst), .sck_fall(sck_fall), .cs_high(cs_high),
    .at_boundary(bit_cnt == 3'd0), .load_en(load_en), .load_byte(load_byte),
    .miso(miso), .miso_oe(miso_oe));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0; data_q <= '0; sr_q <= '0;
      addr_q <= '0; rd_ptr <= '0; seq_ptr <= '0;
      we_q <= 1'b0; arm_q <= 1'b0; seq_on <= 1'b0; id_sel <= '0;
      rd_req <= 1'b0; rd_addr <= '0;
      prog_req <= 1'b0; serase_req <= 1'b0; cerase_req <= 1'b0; wrsr_req <= 1'b0;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      rd_req     <= 1'b0;
      prog_req   <= 1'b0;
      serase_req <= 1'b0;
      cerase_req <= 1'b0;
      wrsr_req   <= 1'b0;

      if (sck_fall && !cs_high && bit_cnt == 3'd0 && load_en && op_q == OP_ID_RD)
        id_sel <= (id_sel == 2'd2) ? 2'd0 : id_sel + 2'd1;

      if (byte_done) begin
        if (byte_cnt == CW'(1)) begin
          op_q   <= rx_byte;
          id_sel <= '0;
        end
        if (byte_cnt >= CW'(2) && byte_cnt <= ADDR_DONE) addr_q <= full_addr;
        if (byte_cnt >= CW'(2) && byte_cnt == final_no) data_q <= rx_byte;
        if (is_read && byte_cnt > CW'(1)) begin
          if (byte_cnt >= data_start) begin
            rd_req  <= 1'b1;
            rd_addr <= next_rd;
            rd_ptr  <= next_rd + 1'b1;
          end else if (byte_cnt == ADDR_DONE) begin
            rd_ptr <= full_addr;
          end
        end
      end

      if (complete) begin
        arm_q <= 1'b0;
        case (op_q)
          OP_WE_SET:      begin we_q <= 1'b1; arm_q <= 1'b1; end
          OP_STAT_UNLOCK: arm_q <= 1'b1;
          OP_WE_CLR:      begin we_q <= 1'b0; seq_on <= 1'b0; end
          OP_STAT_WR: if (arm_q) begin
            sr_q     <= data_q[7:2];
            wr_data  <= data_q;
            wrsr_req <= 1'b1;
            we_q     <= 1'b0;
          end
          OP_PROG_BYTE: if (we_q) begin
            prog_req <= 1'b1; wr_addr <= addr_q; wr_data <= data_q; we_q <= 1'b0;
          end
          OP_PROG_SEQ: if (we_q) begin
            prog_req <= 1'b1;
            wr_data  <= data_q;
            if (seq_on) begin
              wr_addr <= seq_ptr;
              seq_ptr <= seq_ptr + 1'b1;
            end else begin
              wr_addr <= addr_q;
              seq_ptr <= addr_q + 1'b1;
              seq_on  <= 1'b1;
            end
          end
          OP_ERASE_SECT: if (we_q) begin
            serase_req <= 1'b1; wr_addr <= addr_q & SECT_MASK; we_q <= 1'b0;
          end
          OP_ERASE_ALL: if (we_q) begin
            cerase_req <= 1'b1; we_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_req, prog_req, serase_req, cerase_req, wrsr_req})); // R5
  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (prog_req || serase_req || cerase_req) |-> $past(we_q)); // R4
  AST_LATCH_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (serase_req || cerase_req || wrsr_req) |-> !we_q); // R4
  AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (rst)
    (prog_req || serase_req || cerase_req || wrsr_req) |-> $past(cs_rise)); // R5
endmodule

// File: tb/tb_sflash_cmd_front.sv
module tb_sflash_cmd_front;
  localparam time HALF = 40ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic miso, miso_oe, rd_req, prog_req, serase_req, cerase_req, wrsr_req;
  logic [23:0] rd_addr, wr_addr;
  logic [7:0]  rd_data = 8'h00, wr_data;

  always #2ns clk = ~clk;

  sflash_cmd_front dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .busy(busy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .prog_req(prog_req), .serase_req(serase_req), .cerase_req(cerase_req),
    .wrsr_req(wrsr_req), .wr_addr(wr_addr), .wr_data(wr_data));

  function automatic logic [7:0] arr(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= arr(rd_addr);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  typedef struct {
    int          kind;   // 1 program, 2 sector erase, 3 chip erase, 4 status write
    logic [23:0] addr;
    logic [7:0]  data;
    bit          use_addr;
    bit          use_data;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  task automatic push(input int kind, input logic [23:0] a, input logic [7:0] d,
                      input bit ua, input bit ud, input string req);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.use_addr = ua; e.use_data = ud; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item per write strobe
  always @(negedge clk) begin
    if (!rst && (prog_req || serase_req || cerase_req || wrsr_req)) begin
      int k;
      exp_t e;
      k = prog_req ? 1 : serase_req ? 2 : cerase_req ? 3 : 4;
      if (exp_q.size() == 0) begin
        check(0, "R4", "unexpected strobe kind", k, 0);
      end else begin
        e = exp_q.pop_front();
        check(e.kind == k, e.req, "strobe kind", k, e.kind);
        if (e.use_addr) check(wr_addr == e.addr, e.req, "strobe address", wr_addr, e.addr);
        if (e.use_data) check(wr_data == e.data, e.req, "strobe data", wr_data, e.data);
      end
    end
  end

  logic [7:0] tb_tx [16];
  logic [7:0] tb_rx [16];
  bit         tb_on [16];
  bit         tb_off[16];

  task automatic xbyte(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                       output bit on, output bit off);
    rx = '0; on = 1; off = 1;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      #(HALF);
      rx[i] = miso;
      on  &= miso_oe;
      off &= !miso_oe;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input int n, input int last_bits);
    cs_n = 1'b0;
    #(HALF);
    for (int b = 0; b < n; b++)
      xbyte(tb_tx[b], (b == n - 1) ? last_bits : 8, tb_rx[b], tb_on[b], tb_off[b]);
    #(HALF);
    cs_n = 1'b1;
    #(HALF * 6);
  endtask

  task automatic load_cmd(input logic [7:0] op, input logic [23:0] a);
    tb_tx[0] = op; tb_tx[1] = a[23:16]; tb_tx[2] = a[15:8]; tb_tx[3] = a[7:0];
    for (int i = 4; i < 16; i++) tb_tx[i] = 8'h00;
  endtask

  task automatic op1(input logic [7:0] op);
    load_cmd(op, 24'h0);
    frame(1, 8);
  endtask

  task automatic chk_status(input logic [7:0] e, input string req);
    load_cmd(8'h05, 24'h0);
    frame(2, 8);
    check(tb_rx[1] == e, req, "status byte", tb_rx[1], e);
  endtask

  task automatic settle(input string req);
    check(exp_q.size() == 0, req, "strobes still pending", exp_q.size(), 0);
  endtask

  initial begin
    #800us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1ns;
    repeat (10) @(posedge clk);
    #1ns;
    rst = 1'b0;
    #(HALF);

    // reset state
    check(miso_oe == 1'b0, "R14", "oe after reset", miso_oe, 0);
    check(rd_req == 1'b0, "R5", "rd_req after reset", rd_req, 0);
    chk_status(8'h00, "R3");

    // latch set / clear
    op1(8'h06);
    chk_status(8'h02, "R3");
    op1(8'h04);
    chk_status(8'h00, "R3");

    // writes without latch are ignored
    load_cmd(8'h02, 24'h012345); tb_tx[4] = 8'hA5; frame(5, 8);
    load_cmd(8'h20, 24'h0ABCDE); frame(4, 8);
    op1(8'h60);
    settle("R4");
    chk_status(8'h00, "R4");

    // byte program
    op1(8'h06);
    push(1, 24'h012345, 8'hA5, 1, 1, "R6");
    load_cmd(8'h02, 24'h012345); tb_tx[4] = 8'hA5; frame(5, 8);
    settle("R6");
    chk_status(8'h00, "R4");

    // aborted write enable and aborted program
    load_cmd(8'h06, 24'h0); frame(1, 4);
    chk_status(8'h00, "R2");
    op1(8'h06);
    load_cmd(8'h02, 24'h000777); tb_tx[4] = 8'h3C; frame(5, 5);
    settle("R2");
    chk_status(8'h02, "R2");

    // sector erase (latch still set), then chip erase
    push(2, 24'h0AB000, 8'h00, 1, 0, "R7");
    load_cmd(8'h20, 24'h0ABCDE); frame(4, 8);
    settle("R7");
    chk_status(8'h00, "R4");
    op1(8'h06);
    push(3, 24'h0, 8'h00, 0, 0, "R7");
    op1(8'h60);
    settle("R7");

    // sequential program
    op1(8'h06);
    push(1, 24'h0000FF, 8'h11, 1, 1, "R8");
    load_cmd(8'hAF, 24'h0000FF); tb_tx[4] = 8'h11; frame(5, 8);
    push(1, 24'h000100, 8'h22, 1, 1, "R8");
    tb_tx[0] = 8'hAF; tb_tx[1] = 8'h22; frame(2, 8);
    settle("R8");
    chk_status(8'h02, "R8");
    op1(8'h04);
    tb_tx[0] = 8'hAF; tb_tx[1] = 8'h33; frame(2, 8);
    load_cmd(8'hAF, 24'h000200); tb_tx[4] = 8'h44; frame(5, 8);
    settle("R3");
    chk_status(8'h00, "R3");

    // read across a low-byte rollover
    load_cmd(8'h03, 24'h0012FE); frame(8, 8);
    for (int i = 0; i < 4; i++)
      check(tb_off[i], "R14", "oe during header", tb_on[i], 0);
    for (int i = 0; i < 4; i++) begin
      check(tb_on[4+i], "R14", "oe during read data", tb_on[4+i], 1);
      check(tb_rx[4+i] == arr(24'h0012FE + 24'(i)), "R10", "read data",
            tb_rx[4+i], arr(24'h0012FE + 24'(i)));
    end

    // fast read
    load_cmd(8'h0B, 24'h03FFFF); frame(8, 8);
    check(tb_off[4], "R11", "oe during dummy cycle", tb_on[4], 0);
    for (int i = 0; i < 3; i++)
      check(tb_rx[5+i] == arr(24'h03FFFF + 24'(i)), "R11", "fast read data",
            tb_rx[5+i], arr(24'h03FFFF + 24'(i)));

    // continuous status with busy
    busy = 1'b1;
    op1(8'h06);
    load_cmd(8'h05, 24'h0); frame(4, 8);
    for (int i = 1; i < 4; i++)
      check(tb_rx[i] == 8'h03 && tb_on[i], "R12", "streamed status", tb_rx[i], 8'h03);
    busy = 1'b0;
    op1(8'h04);

    // identification stream
    load_cmd(8'h9F, 24'h0); frame(7, 8);
    for (int i = 1; i < 7; i++)
      check(tb_rx[i] == 8'h8C && tb_on[i], "R13", "id byte", tb_rx[i], 8'h8C);

    // unknown opcode
    load_cmd(8'hFF, 24'h0); frame(3, 8);
    check(tb_off[1] && tb_off[2], "R14", "oe on unknown opcode", tb_on[1], 0);
    settle("R14");

    // status write adjacency
    op1(8'h50);
    push(4, 24'h0, 8'hFC, 0, 1, "R9");
    tb_tx[0] = 8'h01; tb_tx[1] = 8'hFC; frame(2, 8);
    settle("R9");
    chk_status(8'hFC, "R9");
    op1(8'h06);
    chk_status(8'hFE, "R9");
    tb_tx[0] = 8'h01; tb_tx[1] = 8'h00; frame(2, 8);
    settle("R9");
    chk_status(8'hFE, "R9");
    op1(8'h06);
    push(4, 24'h0, 8'h40, 0, 1, "R9");
    tb_tx[0] = 8'h01; tb_tx[1] = 8'h40; frame(2, 8);
    settle("R9");
    chk_status(8'h40, "R9");

    // final idle state
    check(miso_oe == 1'b0, "R14", "oe idle at end", miso_oe, 0);
    settle("R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule